// File: doc/BRIEF.md
# Static LCD Backplane Phase Generator

This block produces the common-electrode (backplane) square wave for a direct-drive, non-multiplexed seven-segment LCD, and drives every segment line either in phase or in antiphase with it. A segment that is lit sits in antiphase to the backplane, so it sees a full-swing AC voltage. A dark segment sits in phase with the backplane, so it sees none. Because both halves of the backplane period are equally long, no segment ever carries a DC component. A fast reference clock stands in for the oscillator, and a counter divides it down to the backplane rate.

The block can also act as a slave. A request input asks for this. Once the request has been held for a programmable number of consecutive cycles, the block stops driving its backplane pin and takes its phase from an external backplane input instead. This lets several drivers share one backplane, or lets the backplane come from an outside source. Requests shorter than that window are ignored, so a brief glitch on the sense line cannot flip the display into slave mode. The request and the external backplane each pass through a two-stage synchronizer before use.

Top module: `lcd_bp_phase`

## Requirements
- R1: During synchronous reset (`rst` high at a clock edge), the block clears its state. After the edge, `bp_out` is 0, `bp_oe` is 1 (master mode) and every bit of `seg_out` is 0.
- R2: In all modes the internal backplane is a square wave with period `DIV` (default 128) clock cycles. It is low for the first `DIV/2` edges after reset release and then high for `DIV/2` edges. Counting edges since reset release as n, `bp_out` after edge n equals (n mod `DIV`) >= `DIV/2`.
- R3: In master mode, segment bit i after an edge equals `bp_out` after that same edge XOR `seg_on[i]` as sampled at that edge. A lit segment (1) is therefore in antiphase and a dark segment (0) is in phase, with zero cycles of skew to the backplane. Bit `7*d+s` is segment s (a=0 … g=6) of digit d.
- R4: Slave mode is entered only when the synchronized request has been high for `FILT_CYCLES` (default 16) consecutive samples. The request is synchronized by two flops, so a request driven before edges e..e+F-1 sets slave mode after edge e+F+1. A request held for fewer cycles leaves `bp_oe` at 1 and the segments on the internal phase.
- R5: In slave mode, `bp_oe` is 0. Segment bit i equals the external backplane, as driven before the edge two edges earlier, XOR `seg_on[i]` sampled at the current edge.
- R6: Slave mode is left as soon as the synchronized request is low. When the request is dropped before edge e, `bp_oe` returns to 1 after edge e+2.
- R7: The divider keeps running in slave mode, so on return to master mode the backplane phase matches the reset-relative count of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_req | input | 1 | Request to release the backplane pin and follow `bp_ext` |
| bp_ext | input | 1 | External backplane level used in slave mode |
| seg_on | input | 28 | Segment enables, 1 = lit, bit 7*digit+segment |
| seg_out | output | 28 | Segment drive levels |
| bp_out | output | 1 | Internal backplane level |
| bp_oe | output | 1 | Backplane driver enable, 0 in slave mode |

## Verification
Each result has a fixed latency:
- The backplane and a master-mode segment change settle one edge after their cause.
- An external backplane level reaches the segments on the second edge after it is driven.
- Entry into slave mode appears `FILT_CYCLES`+1 edges after the first request edge.
- Exit from slave mode appears two edges after the request drops.

The driver records every input it applies, indexed by the edge that samples it. From that history and these latencies, it computes the full expected output set for that edge and queues it. The monitor compares only when its edge count equals the queued due edge. Every comparison is made at the falling edge, where all outputs are settled.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;
   localparam int SEGS_PER_DIGIT = 7;

   typedef enum logic {
      BP_MASTER = 1'b0,
      BP_SLAVE  = 1'b1
   } bp_mode_e;

   function automatic logic [SEGS_PER_DIGIT-1:0] phase_word(input logic ph);
      return {SEGS_PER_DIGIT{ph}};
   endfunction
endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
   parameter int DIV = 128
) (
   input  logic clk,
   input  logic rst,
   output logic bp_nxt,
   output logic bp_q
);
   localparam int HALF  = DIV / 2;
   localparam int CNT_W = $clog2(DIV);
   localparam bit POW2  = (DIV & (DIV - 1)) == 0;

   logic [CNT_W-1:0] cnt, cnt_nxt;

   if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
      $error("lcd_bp_divider: DIV must be even and at least 4");
   end

   if (POW2) begin : g_wrap
      assign cnt_nxt = cnt + 1'b1;
      assign bp_nxt  = cnt_nxt[CNT_W-1];
   end else begin : g_cmp
      assign cnt_nxt = (cnt == CNT_W'(DIV - 1)) ? '0 : cnt + 1'b1;
      assign bp_nxt  = (cnt_nxt >= CNT_W'(HALF));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         bp_q <= 1'b0;
      end else begin
         cnt  <= cnt_nxt;
         bp_q <= bp_nxt;
      end
   end

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(DIV - 1));

   assert_toggle_point_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && bp_q != $past(bp_q)) |->
         ($past(cnt) == CNT_W'(HALF - 1) || $past(cnt) == CNT_W'(DIV - 1)));
endmodule

// File: rtl/lcd_bp_sync.sv
module lcd_bp_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("lcd_bp_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[i] <= '0;
         else if (i == 0) stg[i] <= d;
         else stg[i] <= stg[(i == 0) ? 0 : i - 1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lcd_bp_filter.sv
module lcd_bp_filter
   import lcd_bp_pkg::*;
#(
   parameter int FILT_CYCLES = 16
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     req_s,
   output bp_mode_e mode
);
   localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

   logic [CW-1:0] run;

   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("lcd_bp_filter: FILT_CYCLES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run  <= '0;
         mode <= BP_MASTER;
      end else if (!req_s) begin
         run  <= '0;
         mode <= BP_MASTER;
      end else if (run == CW'(FILT_CYCLES - 1)) begin
         mode <= BP_SLAVE;
      end else begin
         run <= run + 1'b1;
      end
   end

   assert_slave_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
      (mode == BP_SLAVE) |-> $past(req_s));

   assert_release_fast_R6: assert property (@(posedge clk) disable iff (rst)
      !req_s |=> (mode == BP_MASTER));
endmodule

// File: rtl/lcd_bp_phase.sv
module lcd_bp_phase
   import lcd_bp_pkg::*;
#(
   parameter int DIV         = 128,
   parameter int DIGITS      = 4,
   parameter int FILT_CYCLES = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NSEG       = DIGITS * SEGS_PER_DIGIT
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            slave_req,
   input  logic            bp_ext,
   input  logic [NSEG-1:0] seg_on,
   output logic [NSEG-1:0] seg_out,
   output logic            bp_out,
   output logic            bp_oe
);
   logic     bp_nxt, bp_q, req_s, ext_s, phase_src;
   bp_mode_e mode;
   logic [SEGS_PER_DIGIT-1:0] dig_q [DIGITS];

   if (DIGITS < 1) begin : g_bad_digits
      $error("lcd_bp_phase: DIGITS must be at least 1");
   end

   lcd_bp_divider #(.DIV(DIV)) u_div (
      .clk(clk), .rst(rst), .bp_nxt(bp_nxt), .bp_q(bp_q));

   lcd_bp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d({slave_req, bp_ext}), .q({req_s, ext_s}));

   lcd_bp_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .req_s(req_s), .mode(mode));

   assign phase_src = (mode == BP_SLAVE) ? ext_s : bp_nxt;

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      always_ff @(posedge clk) begin
         if (rst) dig_q[d] <= '0;
         else dig_q[d] <= seg_on[d*SEGS_PER_DIGIT +: SEGS_PER_DIGIT]
                          ^ phase_word(phase_src);
      end
      assign seg_out[d*SEGS_PER_DIGIT +: SEGS_PER_DIGIT] = dig_q[d];
   end

   assign bp_out = bp_q;
   assign bp_oe  = (mode == BP_MASTER);

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!bp_out && bp_oe && seg_out == '0));

   assert_master_polarity_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode) == BP_MASTER) |->
         (seg_out == ({NSEG{bp_out}} ^ $past(seg_on))));

   assert_slave_follow_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode) == BP_SLAVE) |->
         (seg_out == ({NSEG{$past(ext_s)}} ^ $past(seg_on))));
endmodule

// File: tb/lcd_bp_phase_tb.sv
module lcd_bp_phase_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 128;
   localparam int FILT       = 16;
   localparam int NSEG       = 28;
   localparam int HIST       = 4096;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic slave_req = 1'b0;
   logic bp_ext = 1'b0;
   logic [NSEG-1:0] seg_on = '0;
   logic [NSEG-1:0] seg_out;
   logic bp_out, bp_oe;

   typedef struct {
      int              due;
      logic [NSEG-1:0] seg;
      logic            bp;
      logic            oe;
      string           tag;
   } exp_t;

   exp_t sbq[$];
   exp_t got;
   int k = 0;
   int checks = 0;
   int errors = 0;
   logic            ext_h [HIST];
   logic [NSEG-1:0] pat_h [HIST];
   int              run_h [HIST];

   lcd_bp_phase #(.DIV(DIV), .DIGITS(4), .FILT_CYCLES(FILT), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .slave_req(slave_req), .bp_ext(bp_ext),
      .seg_on(seg_on), .seg_out(seg_out), .bp_out(bp_out), .bp_oe(bp_oe));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (rst) k <= 0;
      else k <= k + 1;
   end

   function automatic logic bp_exp(int e);
      return (e % DIV) >= (DIV / 2);
   endfunction

   function automatic logic slave_after(int e);
      if (e < 3) return 1'b0;
      return run_h[e-2] >= FILT;
   endfunction

   task automatic step(logic [NSEG-1:0] pat, logic req, logic ext, string tag);
      exp_t it;
      int e;
      logic src;
      @(negedge clk);
      e = k + 1;
      slave_req = req;
      bp_ext    = ext;
      seg_on    = pat;
      pat_h[e]  = pat;
      ext_h[e]  = ext;
      run_h[e]  = req ? run_h[e-1] + 1 : 0;
      src       = slave_after(e - 1) ? ext_h[e-2] : bp_exp(e);
      it.due    = e;
      it.bp     = bp_exp(e);
      it.oe     = !slave_after(e);
      it.seg    = {NSEG{src}} ^ pat;
      it.tag    = tag;
      sbq.push_back(it);
   endtask

   task automatic chk1(string tag, logic [NSEG-1:0] act, logic [NSEG-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst && sbq.size() > 0 && sbq[0].due == k) begin
         got = sbq.pop_front();
         checks++;
         if (seg_out !== got.seg || bp_out !== got.bp || bp_oe !== got.oe) begin
            errors++;
            $display("FAIL %s edge %0d actual seg=%h bp=%b oe=%b expected seg=%h bp=%b oe=%b",
                     got.tag, k, seg_out, bp_out, bp_oe, got.seg, got.bp, got.oe);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [NSEG-1:0] pats [5];
      pats[0] = 28'hFFFFFFF;
      pats[1] = 28'hA5A5A5A;
      pats[2] = 28'h5A5A5A5;
      pats[3] = 28'h0000001;
      pats[4] = 28'h8000000;
      for (int i = 0; i < HIST; i++) begin
         ext_h[i] = 1'b0;
         pat_h[i] = '0;
         run_h[i] = 0;
      end
      slave_req = 1'b1;
      bp_ext    = 1'b1;
      seg_on    = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk1("R1 bp_out", {27'b0, bp_out}, '0);
      chk1("R1 bp_oe", {27'b0, bp_oe}, 28'h1);
      chk1("R1 seg_out", seg_out, '0);
      slave_req = 1'b0;
      bp_ext    = 1'b0;
      seg_on    = '0;
      rst       = 1'b0;
      // R2: two full backplane periods, all segments dark
      for (int i = 0; i < 260; i++) step('0, 1'b0, 1'b0, "R2");
      // R3: lit/dark polarity across backplane edges
      for (int i = 0; i < 200; i++) step(pats[i/40], 1'b0, 1'b0, "R3");
      // R4: request one cycle short of the window is ignored
      for (int i = 0; i < FILT - 1; i++) step(pats[1], 1'b1, i[1], "R4");
      for (int i = 0; i < 30; i++) step(pats[1], 1'b0, i[2], "R4");
      // R5: held request, segments follow the external backplane
      for (int i = 0; i < 70; i++) step(pats[i/14], 1'b1, ((i / 5) % 2) == 1, "R5");
      // R6 then R7: release and master phase continuity
      for (int i = 0; i < 150; i++) step(pats[2], 1'b0, i[3], (i < 10) ? "R6" : "R7");
      // R4: request exactly the window length enters slave mode
      for (int i = 0; i < FILT; i++) step(pats[3], 1'b1, 1'b1, "R4");
      for (int i = 0; i < 10; i++) step(pats[3], 1'b0, 1'b1, "R4");
      repeat (4) @(negedge clk);
      chk1("R2 scoreboard drained", 28'(sbq.size()), '0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule